// File: doc/BRIEF.md
# Playback Sample Buffer with DMA Request

This block sits between the write side of an audio playback path and the synthesizer that consumes samples. It keeps one sample queue per channel (left and right). Each queue reports an empty level, a more-than-half level and a full level. Each queue also drives a DMA request line, paired with an acknowledge input. A play control arms a channel. The channel starts handing out samples once at least one word is stored, and it answers each one-cycle sample request from the synthesizer with the oldest stored word.

Stop clears a channel. Pause freezes reading, and resume continues from the same position. A run of sample requests that find the queue dry ends playback. The usable depth is selected by a two-bit size code. It takes effect only while both channels are idle and empty, and the shortest setting reduces the queue to a single holding entry. Host writes and DMA writes share one data bus. A write strobe is a single-cycle pulse that has already been synchronised to the block clock. Flag, request and acknowledge polarities are programmable.

Top module: `sample_fifo_dma`

## Requirements
- R1: The size code sets the depth of each channel in entries: 0 gives MAX_DEPTH, 1 gives MAX_DEPTH/2, 2 gives MAX_DEPTH/4, and 3 gives a single holding entry (bypass). A new code is taken only while both channels are stopped and empty. Otherwise the old depth stays in force.
- R2: The empty flag is asserted when no word is stored. The mid flag is asserted when twice the stored count exceeds the depth. The full flag is asserted when the count equals the depth, and a write arriving while full is discarded.
- R3: Words leave a channel in the order they were written. The word appears on the channel's sample data output, with its valid bit set, in the cycle after the sample request.
- R4: A play control moves a stopped channel to an armed state. Reading starts in the cycle after the first word is present. Sample requests are not answered while the channel is stopped or armed.
- R5: A stop control empties the selected channels, ends their playback and clears their DMA request.
- R6: While paused, a channel answers no sample request and keeps its stored words, and writes are still taken. Resume returns it to reading, starting with the next unread word.
- R7: TMO_LIM consecutive sample requests that find the channel empty end its playback. Any accepted write restarts that count.
- R8: The DMA request is set by play and cleared once the channel is full. While playing, it is set again when twice the count is at most the depth. It is cleared after stop or after playback ends.
- R9: A DMA strobe writes a channel only while that channel's acknowledge is active. While any acknowledge is active, host writes are ignored.
- R10: With flag_low=1 the empty, mid and full outputs are active low (the default is active high). With dreq_low=1 the request outputs are active low. With dack_high=1 the acknowledge inputs are active high (the default is active low).
- R11: In stereo mode a host write with host_ch=1 goes to the right channel and one with host_ch=0 goes to the left channel. In mono mode every host write goes to the left channel, and the right acknowledge and right channel controls have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_size | input | 2 | Depth code (R1) |
| cfg_stereo | input | 1 | 1 = two channels, 0 = left only |
| cfg_flag_low | input | 1 | Level flags active low when 1 |
| cfg_dreq_low | input | 1 | Request outputs active low when 1 |
| cfg_dack_high | input | 1 | Acknowledge inputs active high when 1 |
| host_cs | input | 1 | Host select |
| host_dc | input | 1 | 1 = sample data cycle |
| host_wr | input | 1 | Host write strobe, one cycle |
| host_ch | input | 1 | Host channel select, 1 = right |
| wr_data | input | DATA_W | Shared write data |
| dma_ack | input | 2 | DMA acknowledge per channel (bit 0 left) |
| dma_iow | input | 1 | DMA write strobe, one cycle |
| ctl_play | input | 1 | Play pulse |
| ctl_stop | input | 1 | Stop pulse |
| ctl_pause | input | 1 | Pause pulse |
| ctl_resume | input | 1 | Resume pulse |
| ctl_chan | input | 2 | Channel mask for the control pulses |
| smp_req | input | 2 | Sample request per channel |
| smp_data_l | output | DATA_W | Left sample out |
| smp_data_r | output | DATA_W | Right sample out |
| smp_valid | output | 2 | Sample out valid per channel |
| flag_emp | output | 2 | Empty level per channel |
| flag_mid | output | 2 | More-than-half level per channel |
| flag_ful | output | 2 | Full level per channel |
| dreq | output | 2 | DMA request per channel |
| playing | output | 2 | Channel armed, running or paused |

## Verification
The queue is filled through both the host path and the DMA path at two depths and at the single-entry setting. This shows whether the flag thresholds follow the selected depth rather than a fixed size. Reads are issued in three patterns: steady draining, draining interleaved with pause, and dry requests broken by a single write. These patterns separate correct ordering, frozen reads and the restart of the timeout count. Writes that must be dropped are followed by flag checks, so an accepted write would show up as a changed level: a write to a full queue, a host write during an acknowledge, an unacknowledged strobe, and a write to the wrong channel.

// File: rtl/sfd_pkg.sv
// Shared types for the playback sample buffer.
// Assumes: nothing beyond IEEE 1800-2017.
package sfd_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ARMED = 2'd1,
        ST_RUN   = 2'd2,
        ST_HOLD  = 2'd3
    } play_st_t;
endpackage

// File: rtl/sfd_route.sv
// Write steering: decides which channel queue, if any, takes the current
// write. Host writes are blocked while any DMA acknowledge is active.
// Assumes host_wr and dma_iow are single-cycle strobes already in the clk domain.
module sfd_route (
    input  logic       cfg_stereo,
    input  logic       cfg_dack_high,
    input  logic       host_cs,
    input  logic       host_dc,
    input  logic       host_wr,
    input  logic       host_ch,
    input  logic [1:0] dma_ack,
    input  logic       dma_iow,
    output logic [1:0] wr_en,
    output logic [1:0] dack_act
);
    logic host_ok;
    logic host_right;

    // Normalise acknowledge polarity; right side exists only in stereo.
    always_comb begin
        dack_act[0] = cfg_dack_high ? dma_ack[0] : ~dma_ack[0];
        dack_act[1] = cfg_stereo & (cfg_dack_high ? dma_ack[1] : ~dma_ack[1]);
    end

    // Host path is valid only with no DMA acknowledge outstanding.
    always_comb begin
        host_ok    = host_cs & host_dc & host_wr & (dack_act == 2'b00);
        host_right = cfg_stereo & host_ch;
        wr_en[0]   = (host_ok & ~host_right) | (dma_iow & dack_act[0]);
        wr_en[1]   = (host_ok &  host_right) | (dma_iow & dack_act[1]);
    end
endmodule

// File: rtl/sfd_chan.sv
// One channel queue: storage, level flags, playback state, dry-request
// timeout and DMA request. The depth input may change only while the queue
// is stopped and empty (guaranteed by the parent).
module sfd_chan
    import sfd_pkg::*;
#(
    parameter int DATA_W    = 16,
    parameter int MAX_DEPTH = 128,
    parameter int TMO_LIM   = 64
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic [$clog2(MAX_DEPTH):0]       depth,
    input  logic                             wr_en,
    input  logic [DATA_W-1:0]                wr_data,
    input  logic                             play,
    input  logic                             stop,
    input  logic                             pause,
    input  logic                             resume,
    input  logic                             smp_req,
    output logic [DATA_W-1:0]                rd_data,
    output logic                             rd_valid,
    output logic                             is_emp,
    output logic                             is_mid,
    output logic                             is_ful,
    output logic                             dreq_on,
    output logic                             playing,
    output logic                             busy
);
    localparam int AW = $clog2(MAX_DEPTH);
    localparam int CW = AW + 1;
    localparam int TW = $clog2(TMO_LIM + 1);

    logic [DATA_W-1:0] mem [MAX_DEPTH];
    logic [AW-1:0]     wr_idx, rd_idx;
    logic [CW-1:0]     count;
    logic [TW-1:0]     tmo;
    play_st_t          st;
    logic              accept, pop, dry;

    // Level flags from the fill count against the configured depth.
    always_comb begin
        is_emp  = (count == '0);
        is_ful  = (count == depth);
        is_mid  = ({count, 1'b0} > {1'b0, depth});
        playing = (st != ST_IDLE);
        busy    = playing | ~is_emp;
    end

    // Qualified write, read and dry-request events.
    always_comb begin
        accept = wr_en & ~is_ful & ~stop;
        pop    = (st == ST_RUN) & smp_req & ~is_emp & ~stop;
        dry    = (st == ST_RUN) & smp_req & is_emp;
    end

    // Storage array, written at the write index.
    always_ff @(posedge clk) begin
        if (accept) mem[wr_idx] <= wr_data;
    end

    // Pointers and fill count; indices wrap at the configured depth.
    always_ff @(posedge clk) begin
        if (!rst_n || stop) begin
            wr_idx <= '0;
            rd_idx <= '0;
            count  <= '0;
        end else begin
            if (accept) wr_idx <= ({1'b0, wr_idx} == depth - 1'b1) ? '0 : wr_idx + 1'b1;
            if (pop)    rd_idx <= ({1'b0, rd_idx} == depth - 1'b1) ? '0 : rd_idx + 1'b1;
            count <= count + CW'(accept) - CW'(pop);
        end
    end

    // Sample output register, one cycle after the request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data  <= '0;
            rd_valid <= 1'b0;
        end else begin
            rd_valid <= pop;
            if (pop) rd_data <= mem[rd_idx];
        end
    end

    // Playback state: arm on play, run once data exists, hold on pause.
    always_ff @(posedge clk) begin
        if (!rst_n || stop) begin
            st <= ST_IDLE;
        end else begin
            unique case (st)
                ST_IDLE:  if (play) st <= ST_ARMED;
                ST_ARMED: if (pause) st <= ST_HOLD; else if (!is_emp) st <= ST_RUN;
                ST_RUN:   if (pause) st <= ST_HOLD;
                          else if (dry && tmo == TW'(TMO_LIM - 1)) st <= ST_IDLE;
                ST_HOLD:  if (resume) st <= ST_RUN;
                default:  st <= ST_IDLE;
            endcase
        end
    end

    // Dry-request counter, reloaded by any accepted write.
    always_ff @(posedge clk) begin
        if (!rst_n || stop || accept || st != ST_RUN) tmo <= '0;
        else if (dry) tmo <= tmo + 1'b1;
    end

    // DMA request: set on play, dropped at full, re-raised at half.
    always_ff @(posedge clk) begin
        if (!rst_n || stop)                          dreq_on <= 1'b0;
        else if (is_ful)                             dreq_on <= 1'b0;
        else if (play)                               dreq_on <= 1'b1;
        else if (st == ST_IDLE)                      dreq_on <= 1'b0;
        else if ({count, 1'b0} <= {1'b0, depth})     dreq_on <= 1'b1;
    end

    // R2: count never passes the configured depth.
    p_no_overflow_r2: assert property (@(posedge clk) disable iff (!rst_n)
        count <= depth);
    // R2: a write at full leaves the count unchanged.
    p_full_refuses_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (is_ful && !pop && !stop) |=> (count == $past(count)));
    // R5: stop empties the queue and ends playback.
    p_stop_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
        stop |=> (is_emp && !playing && !dreq_on));
    // R6: no sample is produced from a paused channel.
    p_pause_freeze_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_HOLD) |=> !rd_valid);
    // R8: request is withdrawn once full.
    p_full_drops_req_r8: assert property (@(posedge clk) disable iff (!rst_n)
        is_ful |=> !dreq_on);
endmodule

// File: rtl/sample_fifo_dma.sv
// Top of the playback sample buffer: latches the depth code while idle,
// steers writes, instantiates one queue per channel and applies output
// polarities. Assumes all inputs are synchronous to clk.
module sample_fifo_dma
    import sfd_pkg::*;
#(
    parameter int DATA_W    = 16,
    parameter int MAX_DEPTH = 128,
    parameter int TMO_LIM   = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        cfg_size,
    input  logic              cfg_stereo,
    input  logic              cfg_flag_low,
    input  logic              cfg_dreq_low,
    input  logic              cfg_dack_high,
    input  logic              host_cs,
    input  logic              host_dc,
    input  logic              host_wr,
    input  logic              host_ch,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [1:0]        dma_ack,
    input  logic              dma_iow,
    input  logic              ctl_play,
    input  logic              ctl_stop,
    input  logic              ctl_pause,
    input  logic              ctl_resume,
    input  logic [1:0]        ctl_chan,
    input  logic [1:0]        smp_req,
    output logic [DATA_W-1:0] smp_data_l,
    output logic [DATA_W-1:0] smp_data_r,
    output logic [1:0]        smp_valid,
    output logic [1:0]        flag_emp,
    output logic [1:0]        flag_mid,
    output logic [1:0]        flag_ful,
    output logic [1:0]        dreq,
    output logic [1:0]        playing
);
    localparam int CW = $clog2(MAX_DEPTH) + 1;
    localparam logic [CW-1:0] DEP_FULL = CW'(MAX_DEPTH);
    localparam logic [CW-1:0] DEP_HALF = CW'(MAX_DEPTH / 2);
    localparam logic [CW-1:0] DEP_QRTR = CW'(MAX_DEPTH / 4);
    localparam logic [CW-1:0] DEP_BYP  = CW'(1);

    logic [1:0]        size_q;
    logic [CW-1:0]     depth;
    logic [1:0]        wr_en, dack_act, sel, busy;
    logic [1:0]        emp, mid, ful, req_on;
    logic [DATA_W-1:0] rd_q [2];

    // Depth code is taken only while both channels are stopped and empty.
    always_ff @(posedge clk) begin
        if (!rst_n)          size_q <= 2'd0;
        else if (busy == '0) size_q <= cfg_size;
    end

    // Entry count for the latched code.
    always_comb begin
        unique case (size_q)
            2'd0:    depth = DEP_FULL;
            2'd1:    depth = DEP_HALF;
            2'd2:    depth = DEP_QRTR;
            default: depth = DEP_BYP;
        endcase
    end

    sfd_route u_route (
        .cfg_stereo   (cfg_stereo),
        .cfg_dack_high(cfg_dack_high),
        .host_cs      (host_cs),
        .host_dc      (host_dc),
        .host_wr      (host_wr),
        .host_ch      (host_ch),
        .dma_ack      (dma_ack),
        .dma_iow      (dma_iow),
        .wr_en        (wr_en),
        .dack_act     (dack_act)
    );

    // R9: no host write reaches a queue while an acknowledge is active.
    p_dack_blocks_host_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ((dack_act != 2'b00) && !dma_iow) |-> (wr_en == 2'b00));

    for (genvar c = 0; c < 2; c++) begin : g_chan
        // Control mask: right channel responds only in stereo.
        always_comb sel[c] = ctl_chan[c] & ((c == 0) | cfg_stereo);

        sfd_chan #(
            .DATA_W   (DATA_W),
            .MAX_DEPTH(MAX_DEPTH),
            .TMO_LIM  (TMO_LIM)
        ) u_chan (
            .clk     (clk),
            .rst_n   (rst_n),
            .depth   (depth),
            .wr_en   (wr_en[c]),
            .wr_data (wr_data),
            .play    (ctl_play & sel[c]),
            .stop    (ctl_stop & sel[c]),
            .pause   (ctl_pause & sel[c]),
            .resume  (ctl_resume & sel[c]),
            .smp_req (smp_req[c]),
            .rd_data (rd_q[c]),
            .rd_valid(smp_valid[c]),
            .is_emp  (emp[c]),
            .is_mid  (mid[c]),
            .is_ful  (ful[c]),
            .dreq_on (req_on[c]),
            .playing (playing[c]),
            .busy    (busy[c])
        );
    end

    // Output polarity and data mapping.
    always_comb begin
        smp_data_l = rd_q[0];
        smp_data_r = rd_q[1];
        flag_emp   = emp ^ {2{cfg_flag_low}};
        flag_mid   = mid ^ {2{cfg_flag_low}};
        flag_ful   = ful ^ {2{cfg_flag_low}};
        dreq       = req_on ^ {2{cfg_dreq_low}};
    end
endmodule

// File: tb/sample_fifo_dma_bench.sv
module sample_fifo_dma_bench;
    localparam int DW = 16;

    logic clk = 0, rst_n = 0;
    logic [1:0] cfg_size = 2'd2;
    logic cfg_stereo = 0, cfg_flag_low = 0, cfg_dreq_low = 0, cfg_dack_high = 0;
    logic host_cs = 0, host_dc = 0, host_wr = 0, host_ch = 0;
    logic [DW-1:0] wr_data = '0;
    logic [1:0] dma_ack = 2'b11;
    logic dma_iow = 0;
    logic ctl_play = 0, ctl_stop = 0, ctl_pause = 0, ctl_resume = 0;
    logic [1:0] ctl_chan = 2'b01;
    logic [1:0] smp_req = 0;
    logic [DW-1:0] smp_data_l, smp_data_r;
    logic [1:0] smp_valid, flag_emp, flag_mid, flag_ful, dreq, playing;

    int checks = 0, errors = 0;
    logic [DW-1:0] q0[$], q1[$];

    always #10 clk = ~clk;

    sample_fifo_dma #(.DATA_W(DW), .MAX_DEPTH(16), .TMO_LIM(4)) u_sample_fifo_dma (
        .clk(clk), .rst_n(rst_n), .cfg_size(cfg_size), .cfg_stereo(cfg_stereo),
        .cfg_flag_low(cfg_flag_low), .cfg_dreq_low(cfg_dreq_low),
        .cfg_dack_high(cfg_dack_high), .host_cs(host_cs), .host_dc(host_dc),
        .host_wr(host_wr), .host_ch(host_ch), .wr_data(wr_data), .dma_ack(dma_ack),
        .dma_iow(dma_iow), .ctl_play(ctl_play), .ctl_stop(ctl_stop),
        .ctl_pause(ctl_pause), .ctl_resume(ctl_resume), .ctl_chan(ctl_chan),
        .smp_req(smp_req), .smp_data_l(smp_data_l), .smp_data_r(smp_data_r),
        .smp_valid(smp_valid), .flag_emp(flag_emp), .flag_mid(flag_mid),
        .flag_ful(flag_ful), .dreq(dreq), .playing(playing));

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Driver: host write; pushes the expected sample when it must be kept.
    task automatic hwrite(input logic ch, input logic [DW-1:0] v, input bit keep);
        host_cs = 1; host_dc = 1; host_wr = 1; host_ch = ch; wr_data = v;
        @(negedge clk);
        host_wr = 0; host_cs = 0; host_dc = 0;
        if (keep) begin
            if (ch && cfg_stereo) q1.push_back(v); else q0.push_back(v);
        end
    endtask

    task automatic dwrite(input logic [DW-1:0] v, input bit keep);
        dma_iow = 1; wr_data = v;
        @(negedge clk);
        dma_iow = 0;
        if (keep) q0.push_back(v);
    endtask

    task automatic req(input int ch, input int n);
        repeat (n) begin
            smp_req[ch] = 1'b1;
            @(negedge clk);
            smp_req[ch] = 1'b0;
        end
    endtask

    task automatic ctl(input int kind, input logic [1:0] m);
        ctl_chan = m;
        case (kind)
            0: ctl_play = 1;
            1: ctl_stop = 1;
            2: ctl_pause = 1;
            default: ctl_resume = 1;
        endcase
        @(negedge clk);
        ctl_play = 0; ctl_stop = 0; ctl_pause = 0; ctl_resume = 0;
    endtask

    // Monitor: compares every produced sample against the scoreboard (R3).
    always @(negedge clk) begin
        if (rst_n) begin
            if (smp_valid[0]) begin
                if (q0.size() == 0) chk("R3 R6 unexpected left sample", smp_data_l, 32'hFFFF_FFFF);
                else chk("R3 left order", smp_data_l, q0.pop_front());
            end
            if (smp_valid[1]) begin
                if (q1.size() == 0) chk("R3 unexpected right sample", smp_data_r, 32'hFFFF_FFFF);
                else chk("R3 right order", smp_data_r, q1.pop_front());
            end
        end
    end

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog actual=running expected=done");
        finish_run();
    end

    initial begin
        idle(3); rst_n = 1; idle(2);
        // Reset state (R2, R10 defaults), depth 4 latched (R1)
        chk("R2 reset emp", flag_emp, 2'b11);
        chk("R2 reset mid", flag_mid, 2'b00);
        chk("R2 reset ful", flag_ful, 2'b00);
        chk("R8 reset dreq", dreq, 2'b00);
        chk("R4 reset playing", playing, 2'b00);

        // Fill depth-4 queue (R1, R2)
        hwrite(0, 16'h1001, 1);
        chk("R2 one word emp", flag_emp[0], 0);
        chk("R2 one word mid", flag_mid[0], 0);
        hwrite(0, 16'h1002, 1); hwrite(0, 16'h1003, 1);
        chk("R2 R1 three of four mid", flag_mid[0], 1);
        chk("R1 three of four ful", flag_ful[0], 0);
        hwrite(0, 16'h1004, 1);
        chk("R2 four ful", flag_ful[0], 1);
        hwrite(0, 16'hBAD0, 0);
        chk("R2 write at full ful", flag_ful[0], 1);

        // Play with data present (R4, R8)
        chk("R4 not started before play", smp_valid[0], 0);
        ctl(0, 2'b01);
        chk("R8 play while full keeps dreq low", dreq[0], 0);
        idle(2);
        chk("R4 playing", playing[0], 1);
        req(0, 2); idle(1);
        chk("R8 re-request at half", dreq[0], 1);
        req(0, 2); idle(1);
        chk("R2 drained emp", flag_emp[0], 1);

        // Dry-request timeout with reload (R7)
        req(0, 3);
        chk("R7 three dry", playing[0], 1);
        hwrite(0, 16'h2001, 1); idle(1);
        req(0, 1);
        req(0, 3);
        chk("R7 reload by write", playing[0], 1);
        req(0, 1); idle(1);
        chk("R7 timeout ends play", playing[0], 0);
        chk("R8 dreq off after end", dreq[0], 0);

        // Stop (R5)
        hwrite(0, 16'h3001, 0); hwrite(0, 16'h3002, 0);
        ctl(0, 2'b01); idle(2);
        ctl(1, 2'b01);
        chk("R5 stop emp", flag_emp[0], 1);
        chk("R5 stop playing", playing[0], 0);
        chk("R5 stop dreq", dreq[0], 0);

        // Pause / resume (R6)
        hwrite(0, 16'h4001, 1); hwrite(0, 16'h4002, 1); hwrite(0, 16'h4003, 1);
        ctl(0, 2'b01); idle(2);
        req(0, 1);
        ctl(2, 2'b01);
        req(0, 2); idle(1);
        chk("R6 paused keeps data mid", flag_mid[0], 0);
        chk("R6 paused keeps data emp", flag_emp[0], 0);
        chk("R6 paused still playing", playing[0], 1);
        ctl(3, 2'b01); idle(1);
        req(0, 2); idle(1);
        ctl(1, 2'b01);

        // DMA handshake (R8, R9)
        ctl(0, 2'b01); idle(1);
        chk("R8 dreq on play", dreq[0], 1);
        dma_ack = 2'b10;
        dwrite(16'h5001, 1); dwrite(16'h5002, 1);
        hwrite(0, 16'hBAD1, 0);
        chk("R9 host ignored during ack", flag_mid[0], 0);
        dwrite(16'h5003, 1); dwrite(16'h5004, 1);
        chk("R9 DMA fills ful", flag_ful[0], 1);
        idle(1);
        chk("R8 dreq off at full", dreq[0], 0);
        dma_ack = 2'b11; idle(1);
        req(0, 2); idle(1);
        chk("R8 dreq again at half", dreq[0], 1);
        dwrite(16'hBAD2, 0);
        chk("R9 strobe without ack ignored", flag_mid[0], 0);
        req(0, 2); idle(1);
        ctl(1, 2'b01);

        // Polarity (R10)
        cfg_flag_low = 1; cfg_dreq_low = 1; idle(1);
        chk("R10 emp active low", flag_emp[0], 0);
        chk("R10 ful active low", flag_ful[0], 1);
        chk("R10 dreq active low", dreq[0], 1);
        cfg_dack_high = 1; dma_ack = 2'b00; idle(1);
        dwrite(16'hBAD3, 0);
        chk("R10 low ack inactive when high-active", flag_emp[0], 0);
        dma_ack = 2'b01; idle(1);
        dwrite(16'h6001, 0);
        chk("R10 high ack accepts", flag_emp[0], 1);
        dma_ack = 2'b11; cfg_dack_high = 0; cfg_flag_low = 0; cfg_dreq_low = 0;
        ctl(1, 2'b01);

        // Channel steering (R11)
        cfg_stereo = 1; idle(1);
        hwrite(1, 16'h7001, 0);
        chk("R11 stereo right written", flag_emp[1], 0);
        chk("R11 stereo left untouched", flag_emp[0], 1);
        hwrite(0, 16'h7002, 0);
        chk("R11 stereo left written", flag_emp[0], 0);
        ctl(1, 2'b11);
        cfg_stereo = 0; idle(1);
        hwrite(1, 16'h7003, 0);
        chk("R11 mono goes left", flag_emp[0], 0);
        chk("R11 mono right unused", flag_emp[1], 1);
        dma_ack = 2'b01;
        dwrite(16'hBAD4, 0);
        dma_ack = 2'b11;
        chk("R11 mono right ack ignored", flag_emp[1], 1);

        // Depth change rules (R1)
        cfg_size = 2'd3; idle(2);
        chk("R1 depth held while not empty", flag_ful[0], 0);
        ctl(1, 2'b01); idle(2);
        hwrite(0, 16'h8001, 0);
        chk("R1 bypass ful", flag_ful[0], 1);
        chk("R1 bypass mid", flag_mid[0], 1);
        ctl(1, 2'b01);
        cfg_size = 2'd1; idle(2);
        for (int i = 0; i < 5; i++) hwrite(0, 16'h9000 + 16'(i), 0);
        chk("R1 depth8 mid", flag_mid[0], 1);
        chk("R1 depth8 not ful", flag_ful[0], 0);
        for (int i = 0; i < 3; i++) hwrite(0, 16'h9100 + 16'(i), 0);
        chk("R1 depth8 ful", flag_ful[0], 1);
        ctl(1, 2'b01); idle(2);

        chk("R3 scoreboard drained", q0.size() + q1.size(), 0);
        finish_run();
    end
endmodule